// File: doc/BRIEF.md
# Direct-Mapped Read Cache

This block sits between a processor load port and a slower memory that delivers whole blocks. A byte address from the processor is cut into a tag in the upper bits, a set index in the middle bits and a block offset in the lower bits. Each set holds one line: a valid flag, a stored tag and one data block. Taking the index from the middle bits places consecutive memory blocks in different sets.

A hit needs the selected line to be valid and its stored tag to equal the address tag. On a hit the block offset picks the byte that is returned. On a miss the cache drops its ready signal and asks memory for the whole block. Memory may take any number of cycles to answer. The block then replaces whatever the set held, and the requested byte is returned. Writes are not supported, and only one miss can be outstanding at a time.

The geometry is set by three width parameters. The defaults are 4-bit addresses, 2-byte blocks and 4 sets, which is enough to reproduce a short conflict trace.

Top module: `dm_read_cache`

## Requirements
- R1: The address is split, from most to least significant bit, into TAG_W tag bits, IDX_W index bits and OFF_W offset bits. A refill request carries the block address {tag, index} on mem_addr_o.
- R2: Reset clears every valid flag, so the first access to each set is a miss. Out of reset, req_ready_o=1, rsp_valid_o=0 and mem_req_o=0.
- R3: A request is a hit only when the selected line is valid and its tag matches. A hit answers in the cycle after acceptance, with rsp_valid_o=1 and rsp_hit_o=1, and raises no memory request.
- R4: Byte k of a block sits in bits [8k+7:8k] of mem_data_i. On a hit, rsp_data_o is the byte at the address's offset.
- R5: On a miss, mem_req_o rises in the cycle after acceptance. It stays high, with mem_addr_o stable, until mem_valid_i is seen. req_ready_o stays low from the cycle after acceptance until the response appears.
- R6: On mem_valid_i the whole block is installed. In the next cycle the response appears with rsp_hit_o=0 and the byte at the offset, and req_ready_o returns high.
- R7: An install replaces the set's previous line. With the defaults, the read sequence 0, 1, 13, 8, 0 gives miss, hit, miss, miss, miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request present |
| req_ready_o | output | 1 | Cache can accept a request |
| req_addr_i | input | TAG_W+IDX_W+OFF_W | Byte address of the load |
| rsp_valid_o | output | 1 | Response byte valid, one cycle |
| rsp_data_o | output | 8 | Returned byte |
| rsp_hit_o | output | 1 | 1 when the response came from a hit |
| mem_req_o | output | 1 | Block refill request |
| mem_addr_o | output | TAG_W+IDX_W | Block address being fetched |
| mem_valid_i | input | 1 | Refill block present on mem_data_i |
| mem_data_i | input | 8<<OFF_W | Refill block, byte 0 in the low bits |

## Verification
The bench applies a request at a falling edge, and the next rising edge accepts it. At the falling edge that follows, the outcome must already be visible: a hit response, or a raised refill request with its block address and ready low. For a miss the bench holds off mem_valid_i for a random 0 to 3 cycles and checks at every falling edge that the request stays up and its address stays fixed. After driving the block, the bench looks for the refill response at the falling edge after the edge that sampled mem_valid_i. The expected hit or miss outcome and the expected byte come from a shadow tag table and a memory content function held in the bench.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic {ST_IDLE = 1'b0, ST_FILL = 1'b1} dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int unsigned TAG_W = 1,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  localparam int unsigned SETS = 1 << IDX_W;

  logic [SETS-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[s] <= 1'b0;
        tag_q[s]   <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(s)) begin
        valid_q[s] <= 1'b1;
        tag_q[s]   <= wr_tag_i;
      end
    end
  end

  assign hit_o = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);

  // R6: an installed line is valid on the next cycle
  a_r6_install_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx_i)]);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned OFF_W = 1
) (
  input  logic                           clk_i,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [(dmc_pkg::BYTE_W<<OFF_W)-1:0] wr_blk_i,
  input  logic [IDX_W-1:0]               rd_idx_i,
  input  logic [OFF_W-1:0]               rd_off_i,
  output logic [dmc_pkg::BYTE_W-1:0]     rd_byte_o
);
  localparam int unsigned SETS  = 1 << IDX_W;
  localparam int unsigned BLK_W = dmc_pkg::BYTE_W << OFF_W;

  logic [BLK_W-1:0] blk_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_blk
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_idx_i == IDX_W'(s)) blk_q[s] <= wr_blk_i;
    end
  end

  logic [BLK_W-1:0] rd_blk;
  assign rd_blk    = blk_q[rd_idx_i];
  assign rd_byte_o = rd_blk[{rd_off_i, 3'b000} +: dmc_pkg::BYTE_W];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic hit_i,
  input  logic mem_valid_i,
  output logic ready_o,
  output logic fill_o,
  output logic latch_o,
  output logic install_o
);
  import dmc_pkg::*;
  dmc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_i && !hit_i) state_d = ST_FILL;
      ST_FILL: if (mem_valid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign fill_o    = (state_q == ST_FILL);
  assign latch_o   = accept_i && !hit_i;
  assign install_o = fill_o && mem_valid_i;

  // R5: a refill starts only from a missed, accepted request
  a_r5_fill_from_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_o) |-> $past(accept_i && !hit_i));
endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
  parameter int unsigned TAG_W = 1,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned OFF_W = 1,
  localparam int unsigned A_W   = TAG_W + IDX_W + OFF_W,
  localparam int unsigned BLK_W = dmc_pkg::BYTE_W << OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [A_W-1:0]        req_addr_i,
  output logic                  rsp_valid_o,
  output logic [7:0]            rsp_data_o,
  output logic                  rsp_hit_o,
  output logic                  mem_req_o,
  output logic [TAG_W+IDX_W-1:0] mem_addr_o,
  input  logic                  mem_valid_i,
  input  logic [BLK_W-1:0]      mem_data_i
);
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] req_off;
  assign {req_tag, req_idx, req_off} = req_addr_i;

  logic [A_W-1:0] miss_addr_q;
  logic [TAG_W-1:0] miss_tag;
  logic [IDX_W-1:0] miss_idx;
  logic [OFF_W-1:0] miss_off;
  assign {miss_tag, miss_idx, miss_off} = miss_addr_q;

  logic hit, accept, fill, latch, install;
  logic [7:0] hit_byte;

  assign accept = req_valid_i && req_ready_o;

  dmc_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .accept_i(accept), .hit_i(hit), .mem_valid_i,
    .ready_o(req_ready_o), .fill_o(fill), .latch_o(latch), .install_o(install)
  );

  dmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk_i, .rst_ni,
    .rd_idx_i(req_idx), .rd_tag_i(req_tag), .hit_o(hit),
    .wr_en_i(install), .wr_idx_i(miss_idx), .wr_tag_i(miss_tag)
  );

  dmc_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk_i,
    .wr_en_i(install), .wr_idx_i(miss_idx), .wr_blk_i(mem_data_i),
    .rd_idx_i(req_idx), .rd_off_i(req_off), .rd_byte_o(hit_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) miss_addr_q <= '0;
    else if (latch) miss_addr_q <= req_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      rsp_hit_o   <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (accept && hit) begin
        rsp_valid_o <= 1'b1;
        rsp_data_o  <= hit_byte;
        rsp_hit_o   <= 1'b1;
      end else if (install) begin
        rsp_valid_o <= 1'b1;
        rsp_data_o  <= mem_data_i[{miss_off, 3'b000} +: 8];
        rsp_hit_o   <= 1'b0;
      end
    end
  end

  assign mem_req_o  = fill;
  assign mem_addr_o = {miss_tag, miss_idx};

  a_r3_hit_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> $past(req_valid_i && req_ready_o));
  a_r6_fill_rsp_after_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> $past(mem_req_o && mem_valid_i));
  a_r5_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  a_r5_not_ready_in_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
  a_r6_ready_after_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |=> req_ready_o);
endmodule

// File: tb/dm_read_cache_tb.sv
module dm_read_cache_tb_top;
  localparam int unsigned TAG_W = 1, IDX_W = 2, OFF_W = 1;
  localparam int unsigned A_W = TAG_W + IDX_W + OFF_W;
  localparam int unsigned BLK_W = 8 << OFF_W;
  localparam int unsigned SETS = 1 << IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, mem_valid = 1'b0;
  logic [A_W-1:0] req_addr = '0;
  logic [BLK_W-1:0] mem_data = '0;
  logic req_ready, rsp_valid, rsp_hit, mem_req;
  logic [7:0] rsp_data;
  logic [TAG_W+IDX_W-1:0] mem_addr;

  dm_read_cache #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_hit_o(rsp_hit),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_data_i(mem_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit mvalid [SETS];
  logic [TAG_W-1:0] mtag [SETS];

  function automatic logic [7:0] mem_byte(input logic [A_W-1:0] a);
    return 8'((a * 29 + 8'h5A) ^ (a << 3));
  endfunction

  function automatic logic [BLK_W-1:0] mem_block(input logic [TAG_W+IDX_W-1:0] ba);
    logic [BLK_W-1:0] b;
    for (int k = 0; k < (1 << OFF_W); k++) b[k*8 +: 8] = mem_byte({ba, OFF_W'(k)});
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [A_W-1:0] a, output bit was_hit);
    logic [TAG_W-1:0] tg;
    logic [IDX_W-1:0] ix;
    logic [OFF_W-1:0] of;
    bit exp_hit;
    int lat;
    {tg, ix, of} = a;
    exp_hit = mvalid[ix] && (mtag[ix] == tg);
    @(negedge clk);
    chk(req_ready == 1'b1, "R5 ready idle", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    was_hit = rsp_valid && rsp_hit;
    if (exp_hit) begin
      chk(rsp_valid && rsp_hit, "R3 hit response", int'({rsp_valid, rsp_hit}), 3);
      chk(rsp_data == mem_byte(a), "R4 hit byte", int'(rsp_data), int'(mem_byte(a)));
      chk(!mem_req, "R3 no refill on hit", int'(mem_req), 0);
    end else begin
      chk(!rsp_valid, "R2 miss gives no early response", int'(rsp_valid), 0);
      chk(mem_req && !req_ready, "R5 refill raised, ready low", int'({mem_req, req_ready}), 2);
      chk(mem_addr == {tg, ix}, "R1 block address", int'(mem_addr), int'({tg, ix}));
      lat = $urandom_range(0, 3);
      for (int c = 0; c < lat; c++) begin
        @(negedge clk);
        chk(mem_req && !req_ready && mem_addr == {tg, ix}, "R5 request held", int'(mem_addr), int'({tg, ix}));
      end
      mem_valid = 1'b1; mem_data = mem_block({tg, ix});
      @(negedge clk);
      mem_valid = 1'b0; mem_data = '0;
      chk(rsp_valid && !rsp_hit, "R6 refill response", int'({rsp_valid, rsp_hit}), 2);
      chk(rsp_data == mem_byte(a), "R6 refill byte", int'(rsp_data), int'(mem_byte(a)));
      chk(req_ready && !mem_req, "R6 ready restored", int'({req_ready, mem_req}), 2);
      mvalid[ix] = 1'b1; mtag[ix] = tg;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    bit h;
    bit exp_trace [5] = '{0, 1, 0, 0, 0};
    logic [A_W-1:0] trace [5] = '{4'd0, 4'd1, 4'd13, 4'd8, 4'd0};
    void'($urandom(32'd7));
    for (int s = 0; s < SETS; s++) begin mvalid[s] = 0; mtag[s] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R2 reset state",
        int'({req_ready, rsp_valid, mem_req}), 4);
    rst_n = 1'b1;
    // R7 conflict trace
    for (int i = 0; i < 5; i++) begin
      do_read(trace[i], h);
      chk(h == exp_trace[i], "R7 trace outcome", int'(h), int'(exp_trace[i]));
    end
    // R3 R4: both bytes of a resident block
    do_read(4'd8, h);
    do_read(4'd9, h);
    chk(h == 1'b1, "R4 second byte hits", int'(h), 1);
    for (int i = 0; i < 300; i++) begin
      do_read(A_W'($urandom_range(0, (1 << A_W) - 1)), h);
    end
    finish_run();
  end
endmodule